// File: doc/BRIEF.md
# Dual-Channel DAC Serial Command Front End

This block is the digital front end of a two-channel, 8-bit voltage-output converter. A host talks to it over three wires: an active-low select, a serial clock and a data line. While select is low, one bit is taken on each falling edge of the serial clock, most significant bit first, into a 16-bit command shifter. The serial lines are slow compared with the system clock. The block brings them into its clock domain with a synchroniser and looks for edges there.

A finished word is decoded into a 2-bit target code, a speed flag, a power flag and an 8-bit value. Three registers hold the data: channel A, channel B and a holding buffer. Channel B can be loaded directly, or staged in the buffer and moved across in the same cycle that channel A is written, so both outputs change together. A word is finished either by its sixteenth bit or by select rising early. A one-cycle strobe marks each commit.

The sequencer has three states. `ST_IDLE` waits for select to fall; that transition (start) clears the shifter and the bit counter. `ST_SHIFT` takes bits. It leaves to `ST_HOLD` on the sixteenth bit (full commit), or back to `ST_IDLE` when select rises (early commit if any bit has arrived, abandon if none). `ST_HOLD` ignores serial clocks until select rises (release to `ST_IDLE`).

Top module: `dac_serial_ctrl`

## Requirements
- R1: After reset, `chan_a`, `chan_b` and `hold_q` are 0, `fast_mode` and `pwr_down` are 0, and `upd_stb` is 0.
- R2: Serial clock falls while select is high do not change any output and commit nothing; a transfer starts only on a select fall.
- R3: The sixteenth falling serial clock edge commits the word by itself. Further clock falls and the later select rise commit nothing more.
- R4: If select rises after 1 to 15 bits, the shifter is committed with the received bits right-aligned and zeros above them. If select rises after 0 bits, nothing is committed.
- R5: Target code {bit 15, bit 12} = 00 writes the value field (bits 11..4) to both `hold_q` and `chan_b`.
- R6: Target code 01 writes the value to `hold_q` only; `chan_a` and `chan_b` keep their contents.
- R7: Target code 10 writes the value to `chan_a`, and in the same cycle loads `chan_b` with the `hold_q` content from before the commit.
- R8: Target code 11 leaves `chan_a`, `chan_b` and `hold_q` unchanged.
- R9: Every committed word, whatever its target code, sets `fast_mode` from bit 14 and `pwr_down` from bit 13 (1 = fast, 1 = power-down).
- R10: `upd_stb` is high for exactly one cycle per commit. The data registers and flags change only in that cycle. A commit shows on the outputs four system clocks after the edge that triggers it arrives at the pins.
- R11: If select rises in the same synchronised cycle as a serial clock fall, that fall counts as the last bit of the word, and exactly one commit results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Serial select, active low |
| sclk_in | input | 1 | Serial clock; bits taken on its falling edge |
| sdata_in | input | 1 | Serial data, MSB first |
| upd_stb | output | 1 | One-cycle pulse on each commit |
| chan_a | output | 8 | Channel A register |
| chan_b | output | 8 | Channel B register |
| hold_q | output | 8 | Holding buffer, visible for observation |
| fast_mode | output | 1 | 1 = fast settling mode |
| pwr_down | output | 1 | 1 = power-down requested |

## Verification
Two events can fall in one synchronised cycle: the select rise, which commits early, and a serial clock fall, which shifts in a bit and may be the sixteenth. The bench drives both pins on the same system clock edge. It does this once on the sixteenth bit and once on a shorter word. Its reference model treats the fall as the final bit. It then expects exactly one strobe, carrying the longer word, four clocks later, and any second strobe or wrong register value is reported. The A write and the buffer-to-B move also share a cycle, and are judged by checking that both channels change on the same strobe.

// File: rtl/dsc_pkg.sv
`timescale 1ns/1ps
package dsc_pkg;
    localparam int WORD_W  = 16;
    localparam int VAL_W   = 8;
    localparam int SEL_HI  = 15;
    localparam int SPD_BIT = 14;
    localparam int PWR_BIT = 13;
    localparam int SEL_LO  = 12;
    localparam int VAL_LSB = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_HOLD  = 2'd2
    } seq_state_t;

    typedef enum logic [1:0] {
        TGT_BUF_AND_B = 2'b00,
        TGT_BUF_ONLY  = 2'b01,
        TGT_A_XFER_B  = 2'b10,
        TGT_RESERVED  = 2'b11
    } target_t;
endpackage

// File: rtl/dsc_line_sync.sv
`timescale 1ns/1ps
module dsc_line_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic level,
    output logic fell,
    output logic rose
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= RST_VAL;
                    else        chain_q[g] <= line_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= RST_VAL;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign level = chain_q[STAGES-1];
    assign fell  = prev_q & ~chain_q[STAGES-1];
    assign rose  = ~prev_q & chain_q[STAGES-1];

    a_r2_edges_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(fell && rose));
endmodule

// File: rtl/dsc_shift_fsm.sv
`timescale 1ns/1ps
module dsc_shift_fsm
    import dsc_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel_fall,
    input  logic         sel_rise,
    input  logic         sck_fall,
    input  logic         din,
    output logic         cmd_valid,
    output logic [W-1:0] cmd_word
);
    localparam int CNT_W = $clog2(W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(W - 1);

    seq_state_t      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [W-1:0]    sh_q, sh_d, sh_in;
    logic            commit_d;
    logic [W-1:0]    commit_word_d;

    assign sh_in = {sh_q[W-2:0], din};

    // next-state and commit decision
    always_comb begin
        state_d       = state_q;
        cnt_d         = cnt_q;
        sh_d          = sh_q;
        commit_d      = 1'b0;
        commit_word_d = sh_q;
        unique case (state_q)
            ST_IDLE: begin
                if (sel_fall) begin
                    state_d = ST_SHIFT;
                    cnt_d   = '0;
                    sh_d    = '0;
                end
            end
            ST_SHIFT: begin
                if (sel_rise) begin
                    state_d = ST_IDLE;
                    if (sck_fall) begin
                        commit_d      = 1'b1;
                        commit_word_d = sh_in;
                    end else if (cnt_q != '0) begin
                        commit_d      = 1'b1;
                        commit_word_d = sh_q;
                    end
                end else if (sck_fall) begin
                    sh_d  = sh_in;
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_q == LAST_BIT) begin
                        state_d       = ST_HOLD;
                        commit_d      = 1'b1;
                        commit_word_d = sh_in;
                    end
                end
            end
            ST_HOLD: begin
                if (sel_rise) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            sh_q    <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            sh_q    <= sh_d;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_word  <= '0;
        end else begin
            cmd_valid <= commit_d;
            if (commit_d) cmd_word <= commit_word_d;
        end
    end

    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(W));
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> !cmd_valid);
    a_r3_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |=> !cmd_valid);
    a_r4_empty_abandon: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && sel_rise && !sck_fall && cnt_q == '0) |=> !cmd_valid);
endmodule

// File: rtl/dsc_latch_bank.sv
`timescale 1ns/1ps
module dsc_latch_bank
    import dsc_pkg::*;
#(
    parameter int W = WORD_W,
    parameter int V = VAL_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmd_valid,
    input  logic [W-1:0] cmd_word,
    output logic         upd_stb,
    output logic [V-1:0] chan_a,
    output logic [V-1:0] chan_b,
    output logic [V-1:0] hold_q,
    output logic         fast_mode,
    output logic         pwr_down
);
    target_t      tgt;
    logic [V-1:0] val;

    assign tgt = target_t'({cmd_word[SEL_HI], cmd_word[SEL_LO]});
    assign val = cmd_word[VAL_LSB +: V];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_a    <= '0;
            chan_b    <= '0;
            hold_q    <= '0;
            fast_mode <= 1'b0;
            pwr_down  <= 1'b0;
            upd_stb   <= 1'b0;
        end else begin
            upd_stb <= cmd_valid;
            if (cmd_valid) begin
                fast_mode <= cmd_word[SPD_BIT];
                pwr_down  <= cmd_word[PWR_BIT];
                unique case (tgt)
                    TGT_BUF_AND_B: begin
                        hold_q <= val;
                        chan_b <= val;
                    end
                    TGT_BUF_ONLY: hold_q <= val;
                    TGT_A_XFER_B: begin
                        chan_a <= val;
                        chan_b <= hold_q;
                    end
                    TGT_RESERVED: ;
                    default: ;
                endcase
            end
        end
    end

    a_r10_quiet_without_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> ($stable(chan_a) && $stable(chan_b) && $stable(hold_q)
                        && $stable(fast_mode) && $stable(pwr_down)));
    a_r8_reserved_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && tgt == TGT_RESERVED) |=>
            ($stable(chan_a) && $stable(chan_b) && $stable(hold_q)));
    a_r7_b_from_buffer: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && tgt == TGT_A_XFER_B) |=> (chan_b == $past(hold_q)));
    a_r5_b_matches_buffer: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && tgt == TGT_BUF_AND_B) |=> (chan_b == hold_q));
    a_r6_channels_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && tgt == TGT_BUF_ONLY) |=> ($stable(chan_a) && $stable(chan_b)));
endmodule

// File: rtl/dac_serial_ctrl.sv
`timescale 1ns/1ps
module dac_serial_ctrl
    import dsc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_n,
    input  logic             sclk_in,
    input  logic             sdata_in,
    output logic             upd_stb,
    output logic [VAL_W-1:0] chan_a,
    output logic [VAL_W-1:0] chan_b,
    output logic [VAL_W-1:0] hold_q,
    output logic             fast_mode,
    output logic             pwr_down
);
    logic sel_lvl, sel_fall, sel_rise;
    logic sck_lvl, sck_fall, sck_rise;
    logic dat_lvl, dat_fall, dat_rise;
    logic              cmd_valid;
    logic [WORD_W-1:0] cmd_word;

    dsc_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sel_sync (
        .clk(clk), .rst_n(rst_n), .line_in(sel_n),
        .level(sel_lvl), .fell(sel_fall), .rose(sel_rise));

    dsc_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sck_sync (
        .clk(clk), .rst_n(rst_n), .line_in(sclk_in),
        .level(sck_lvl), .fell(sck_fall), .rose(sck_rise));

    dsc_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_dat_sync (
        .clk(clk), .rst_n(rst_n), .line_in(sdata_in),
        .level(dat_lvl), .fell(dat_fall), .rose(dat_rise));

    dsc_shift_fsm #(.W(WORD_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .sel_fall(sel_fall), .sel_rise(sel_rise),
        .sck_fall(sck_fall), .din(dat_lvl),
        .cmd_valid(cmd_valid), .cmd_word(cmd_word));

    dsc_latch_bank #(.W(WORD_W), .V(VAL_W)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .upd_stb(upd_stb), .chan_a(chan_a), .chan_b(chan_b), .hold_q(hold_q),
        .fast_mode(fast_mode), .pwr_down(pwr_down));

    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (chan_a == '0 && chan_b == '0 && !upd_stb));
    a_r10_stb_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        upd_stb |=> !upd_stb);
endmodule

// File: tb/dac_serial_ctrl_tb_top.sv
`timescale 1ns/1ps
module dac_serial_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_n = 1'b1;
    logic sclk_in = 1'b1;
    logic sdata_in = 1'b0;
    logic       upd_stb, fast_mode, pwr_down;
    logic [7:0] chan_a, chan_b, hold_q;

    always #5 clk = ~clk;

    dac_serial_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk_in(sclk_in),
        .sdata_in(sdata_in), .upd_stb(upd_stb), .chan_a(chan_a),
        .chan_b(chan_b), .hold_q(hold_q), .fast_mode(fast_mode),
        .pwr_down(pwr_down));

    int vectors = 0;
    int miscompares = 0;
    string phase = "R1";

    // reference model state
    logic [7:0]  m_a = 0, m_b = 0, m_h = 0;
    logic        m_f = 0, m_p = 0, m_stb = 0;
    logic [15:0] m_sh = 0;
    int          m_cnt = 0;
    bit          m_active = 0, m_done = 0;
    int          pend = 0;
    logic [15:0] pend_word = 0;
    int          stb_seen = 0;

    localparam int LAT = 4;

    task automatic apply_word(input logic [15:0] w);
        logic [7:0] v;
        v = w[11:4];
        m_f = w[14];
        m_p = w[13];
        case ({w[15], w[12]})
            2'b00: begin m_h = v; m_b = v; end
            2'b01: m_h = v;
            2'b10: begin m_b = m_h; m_a = v; end
            default: ;
        endcase
        m_stb = 1'b1;
    endtask

    task automatic cmp(input string what, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual %h expected %h", phase, what, act, exp);
        end
    endtask

    // one system clock: advance model, compare all outputs
    task automatic tick();
        @(negedge clk);
        m_stb = 1'b0;
        if (pend > 0) begin
            pend--;
            if (pend == 0) apply_word(pend_word);
        end
        if (upd_stb === 1'b1) stb_seen++;
        cmp("chan_a", chan_a, m_a);
        cmp("chan_b", chan_b, m_b);
        cmp("hold_q", hold_q, m_h);
        cmp("fast_mode", {7'd0, fast_mode}, {7'd0, m_f});
        cmp("pwr_down", {7'd0, pwr_down}, {7'd0, m_p});
        cmp("upd_stb(R10)", {7'd0, upd_stb}, {7'd0, m_stb});
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic schedule(input logic [15:0] w);
        pend = LAT;
        pend_word = w;
    endtask

    task automatic sel_low();
        sel_n = 1'b0;
        m_active = 1; m_done = 0; m_sh = 0; m_cnt = 0;
        ticks(6);
    endtask

    // one bit: data set, clock high, clock falls (sample)
    task automatic clk_bit(input logic b, input bit with_rise);
        sdata_in = b;
        sclk_in = 1'b1;
        ticks(4);
        sclk_in = 1'b0;
        if (with_rise) sel_n = 1'b1;
        if (m_active && !m_done) begin
            m_sh = {m_sh[14:0], b};
            m_cnt++;
            if (m_cnt == 16) begin m_done = 1; schedule(m_sh); end
        end
        if (with_rise) begin
            if (m_active && !m_done && m_cnt > 0) schedule(m_sh);
            m_active = 0;
        end
        ticks(4);
    endtask

    task automatic sel_high();
        sclk_in = 1'b1;
        ticks(3);
        sel_n = 1'b1;
        if (m_active && !m_done && m_cnt > 0) schedule(m_sh);
        m_active = 0;
        ticks(8);
    endtask

    task automatic send_word(input logic [15:0] w);
        sel_low();
        for (int i = 15; i >= 0; i--) clk_bit(w[i], 1'b0);
        sel_high();
    endtask

    function automatic logic [15:0] mk(input logic [1:0] tgt, input logic spd,
                                        input logic pwr, input logic [7:0] v);
        return {tgt[1], spd, pwr, tgt[0], v, 4'h0};
    endfunction

    task automatic named(input string req, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        #2000000;
        miscompares++;
        $display("FAIL watchdog expired actual running expected finished");
        finish_run();
    end

    initial begin
        int s0;
        // R1: reset values
        ticks(3);
        named("R1 chan_a after reset", chan_a, 8'h00);
        named("R1 hold_q after reset", hold_q, 8'h00);
        rst_n = 1'b1;
        ticks(4);
        named("R1 flags after reset", {6'd0, fast_mode, pwr_down}, 8'h00);

        // R5: target 00 writes buffer and B
        phase = "R5";
        send_word(mk(2'b00, 1'b0, 1'b0, 8'h5A));
        named("R5 chan_b", chan_b, 8'h5A);
        named("R5 hold_q", hold_q, 8'h5A);

        // R6 + R9: buffer only, fast mode
        phase = "R6";
        send_word(mk(2'b01, 1'b1, 1'b0, 8'hC3));
        named("R6 chan_b kept", chan_b, 8'h5A);
        named("R6 hold_q", hold_q, 8'hC3);
        named("R9 fast_mode set", {7'd0, fast_mode}, 8'h01);

        // R7: A write with buffer moved to B on the same strobe
        phase = "R7";
        s0 = stb_seen;
        send_word(mk(2'b10, 1'b1, 1'b0, 8'h81));
        named("R7 chan_a", chan_a, 8'h81);
        named("R7 chan_b from buffer", chan_b, 8'hC3);
        named("R10 one strobe", 8'(stb_seen - s0), 8'h01);

        // R8 + R9: reserved leaves data, flags still follow
        phase = "R8";
        send_word(mk(2'b11, 1'b0, 1'b1, 8'hFF));
        named("R8 chan_a kept", chan_a, 8'h81);
        named("R8 hold_q kept", hold_q, 8'hC3);
        named("R9 pwr_down via reserved", {6'd0, fast_mode, pwr_down}, 8'h01);

        // R2: clocks while select high are ignored
        phase = "R2";
        s0 = stb_seen;
        for (int i = 0; i < 20; i++) clk_bit(1'b1, 1'b0);
        named("R2 no strobe while deselected", 8'(stb_seen - s0), 8'h00);
        named("R2 chan_b unchanged", chan_b, 8'hC3);

        // R4: early rise after 6 bits 101101 -> word 0x002D
        phase = "R4";
        sel_low();
        clk_bit(1,0); clk_bit(0,0); clk_bit(1,0);
        clk_bit(1,0); clk_bit(0,0); clk_bit(1,0);
        sel_high();
        named("R4 partial to chan_b", chan_b, 8'h02);
        named("R4 partial flags", {6'd0, fast_mode, pwr_down}, 8'h00);

        // R4: select pulse with no bits commits nothing
        s0 = stb_seen;
        sel_low();
        sel_high();
        named("R4 empty select no strobe", 8'(stb_seen - s0), 8'h00);

        // R11: sixteenth fall together with select rise
        phase = "R11";
        begin
            logic [15:0] w;
            w = mk(2'b10, 1'b1, 1'b1, 8'h3C);
            s0 = stb_seen;
            sel_low();
            for (int i = 15; i >= 1; i--) clk_bit(w[i], 1'b0);
            clk_bit(w[0], 1'b1);
            ticks(10);
            named("R11 single commit", 8'(stb_seen - s0), 8'h01);
            named("R11 chan_a", chan_a, 8'h3C);
        end

        // R11: coincidence on a short word, 3 bits 110 plus falling bit 1 -> 0x000D
        s0 = stb_seen;
        sel_low();
        clk_bit(1,0); clk_bit(1,0); clk_bit(0,0);
        clk_bit(1,1);
        ticks(10);
        named("R11 short coincident word chan_b", chan_b, 8'h00);
        named("R11 short single commit", 8'(stb_seen - s0), 8'h01);

        // R3: extra clocks after 16 bits and the rise commit nothing more
        phase = "R3";
        begin
            logic [15:0] w;
            w = mk(2'b00, 1'b0, 1'b0, 8'hFF);
            s0 = stb_seen;
            sel_low();
            for (int i = 15; i >= 0; i--) clk_bit(w[i], 1'b0);
            for (int i = 0; i < 5; i++) clk_bit(1'b0, 1'b0);
            sel_high();
            named("R3 one commit only", 8'(stb_seen - s0), 8'h01);
            named("R3 chan_b full scale", chan_b, 8'hFF);
        end

        // R5 boundary: zero value
        phase = "R5";
        send_word(mk(2'b00, 1'b1, 1'b0, 8'h00));
        named("R5 chan_b zero", chan_b, 8'h00);
        named("R7 chan_a kept by target 00", chan_a, 8'h3C);

        ticks(5);
        finish_run();
    end
endmodule